// File: doc/BRIEF.md
# Trimmable Microframe Start-of-Frame Timer

This block paces the microframes of a high-speed USB host controller. It counts clocks of the high-speed bit clock and raises a one-clock start-of-frame strobe each time a microframe ends. A running microframe index advances with each strobe. The period is trimmed by an 8-bit software register, whose low six bits hold a trim step. This lets firmware correct for error in the clock source.

The trim register sits in an always-on reset domain, so it keeps its value across core resets. It can only be changed while the controller reports itself halted. While halted, the timer rests at zero. When the controller leaves the halted state, the timer starts a fresh microframe. The register port is a plain address-match and write-enable port with a combinational read path. The block has no data stream, so it has no valid/ready handshake.

Top module: `usb_sof_timer`

## Requirements
- R1: One microframe lasts BASE_LEN + 16*T clocks, where T is bits 5:0 of the trim register and BASE_LEN defaults to 59488. This gives 59488 clocks at T=0, 60000 at T=32 and 60496 at T=63. Consecutive strobes are exactly that many clocks apart.
- R2: With `reg_sel` high, `reg_rdata` returns {2'b00, T}. Bits 7:6 ignore writes and always read 0. With `reg_sel` low, `reg_rdata` is 0.
- R3: The always-on reset `aon_rst_n` sets the register to 0x20 (T=32), which gives a 60000-clock microframe at the default base.
- R4: The core reset `core_rst_n` clears the counter, the strobe and the microframe index, and leaves the trim register unchanged. When core reset is released with `halted` low, the first strobe comes BASE_LEN + 16*T clocks later.
- R5: A write (`reg_sel` and `reg_we` high) while `halted` is 0 is ignored, and the register keeps its value.
- R6: While `halted` is 1, the counter is held at zero, `sof_pulse` stays low and the index holds its value. On the first rising edge with `halted` low, a new microframe starts, and its strobe appears BASE_LEN + 16*T clocks later.
- R7: `sof_pulse` is high for exactly one clock per microframe. Each strobe raises `uframe_idx` by one, modulo 2^IDX_W.
- R8: A write while `halted` is 1 takes effect at that rising edge and can be read back in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed bit clock driving the counter |
| core_rst_n | input | 1 | Asynchronous active-low core reset (counter and index) |
| aon_rst_n | input | 1 | Asynchronous active-low always-on reset (trim register) |
| halted | input | 1 | Controller halted status; 1 allows trim writes and idles the timer |
| reg_sel | input | 1 | Address match for the trim register |
| reg_we | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | 8 | Write data; bits 5:0 are the trim step |
| reg_rdata | output | 8 | Read data, {2'b00, trim} when selected, else 0 |
| sof_pulse | output | 1 | One-clock start-of-frame strobe |
| uframe_idx | output | IDX_W | Microframe index, counts strobes |

## Verification
After the first rising edge with `halted` low, the strobe is due exactly BASE_LEN + 16*T edges later. The bench counts falling edges from the cycle in which it releases `halted`, and requires the strobe to appear on that exact count and not before. The register result is due one edge after the write. Because the read path is combinational, the bench reads it back in the following low phase. The strobe and the index are registered, so a halt or a core reset shows at the next sample. The bench drives every input on the falling edge and samples just after it. A full-length instance checks the 60000- and 60496-clock periods. A second instance with a small base runs random trims, writes made while running, halts and resets.

// File: rtl/usb_sof_pkg.sv
package usb_sof_pkg;
  localparam int TRIM_W     = 6;
  localparam int REG_W      = 8;
  localparam int RSVD_W     = REG_W - TRIM_W;
  localparam int STEP_SHIFT = 4;
  localparam int DEF_BASE   = 59488;
  localparam int DEF_TRIM   = 32;

  typedef logic [TRIM_W-1:0] trim_t;
  typedef logic [REG_W-1:0]  reg_t;
endpackage

// File: rtl/sof_trim_reg.sv
module sof_trim_reg
  import usb_sof_pkg::*;
#(
  parameter int TRIM_RST = DEF_TRIM
) (
  input  logic  clk,
  input  logic  aon_rst_n,
  input  logic  halted,
  input  logic  reg_sel,
  input  logic  reg_we,
  input  reg_t  reg_wdata,
  output reg_t  reg_rdata,
  output trim_t trim_o
);
  trim_t trim_q;
  logic  wr_ok;

  assign wr_ok = reg_sel && reg_we && halted;

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n)  trim_q <= TRIM_RST[TRIM_W-1:0];
    else if (wr_ok)  trim_q <= reg_wdata[TRIM_W-1:0];
  end

  assign reg_rdata = reg_sel ? {{RSVD_W{1'b0}}, trim_q} : '0;
  assign trim_o    = trim_q;

  // trim value may only move while the controller is halted
  assert_frozen_run_R5: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !halted |=> $stable(trim_q));
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (reg_sel && reg_we && halted) |=> (trim_o == $past(reg_wdata[TRIM_W-1:0])));
endmodule

// File: rtl/sof_len_calc.sv
module sof_len_calc
  import usb_sof_pkg::*;
#(
  parameter int BASE_LEN = DEF_BASE,
  parameter int CNT_W    = 16
) (
  input  trim_t            trim_i,
  output logic [CNT_W-1:0] last_o
);
  localparam int MAX_LEN = BASE_LEN + ((2**TRIM_W - 1) << STEP_SHIFT);

  generate
    if (MAX_LEN > 2**CNT_W) begin : g_bad_width
      $error("counter width too small for longest microframe");
    end
  endgenerate

  assign last_o = CNT_W'(BASE_LEN - 1) + (CNT_W'(trim_i) << STEP_SHIFT);
endmodule

// File: rtl/sof_frame_ctr.sv
module sof_frame_ctr #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             core_rst_n,
  input  logic             halted,
  input  logic [CNT_W-1:0] last_i,
  output logic             sof_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == last_i);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cnt_q <= '0;
      sof_o <= 1'b0;
      idx_o <= '0;
    end else if (halted) begin
      cnt_q <= '0;
      sof_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sof_o <= 1'b1;
      idx_o <= idx_o + IDX_W'(1);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      sof_o <= 1'b0;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    cnt_q <= last_i);
  assert_halt_idle_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |=> (cnt_q == '0 && !sof_o && $stable(idx_o)));
  assert_sof_single_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    sof_o |=> !sof_o);
  assert_idx_step_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(sof_o) |-> (idx_o == $past(idx_o) + IDX_W'(1)));
  assert_sof_wraps_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    sof_o |-> (cnt_q == '0));
endmodule

// File: rtl/usb_sof_timer.sv
module usb_sof_timer
  import usb_sof_pkg::*;
#(
  parameter int BASE_LEN = DEF_BASE,
  parameter int TRIM_RST = DEF_TRIM,
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 14
) (
  input  logic             clk,
  input  logic             core_rst_n,
  input  logic             aon_rst_n,
  input  logic             halted,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             sof_pulse,
  output logic [IDX_W-1:0] uframe_idx
);
  trim_t            trim;
  logic [CNT_W-1:0] last;

  sof_trim_reg #(.TRIM_RST(TRIM_RST)) u_reg (
    .clk       (clk),
    .aon_rst_n (aon_rst_n),
    .halted    (halted),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .trim_o    (trim)
  );

  sof_len_calc #(.BASE_LEN(BASE_LEN), .CNT_W(CNT_W)) u_len (
    .trim_i (trim),
    .last_o (last)
  );

  sof_frame_ctr #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctr (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .halted     (halted),
    .last_i     (last),
    .sof_o      (sof_pulse),
    .idx_o      (uframe_idx)
  );

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!aon_rst_n)
    reg_rdata[7:6] == 2'b00);
endmodule

// File: tb/tb_usb_sof_timer.sv
module tb_usb_sof_timer;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 14;
  localparam int SMALL_BASE = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit s_done  = 0;
  bit b_done  = 0;

  // full-length instance
  logic b_core, b_aon, b_halt, b_sel, b_we, b_sof;
  logic [7:0] b_wd, b_rd;
  logic [IDX_W-1:0] b_idx;

  usb_sof_timer #(.IDX_W(IDX_W)) dut (
    .clk(clk), .core_rst_n(b_core), .aon_rst_n(b_aon), .halted(b_halt),
    .reg_sel(b_sel), .reg_we(b_we), .reg_wdata(b_wd), .reg_rdata(b_rd),
    .sof_pulse(b_sof), .uframe_idx(b_idx));

  // short-base instance for many frames
  logic s_core, s_aon, s_halt, s_sel, s_we, s_sof;
  logic [7:0] s_wd, s_rd;
  logic [IDX_W-1:0] s_idx;

  usb_sof_timer #(.BASE_LEN(SMALL_BASE), .IDX_W(IDX_W)) dut_small (
    .clk(clk), .core_rst_n(s_core), .aon_rst_n(s_aon), .halted(s_halt),
    .reg_sel(s_sel), .reg_we(s_we), .reg_wdata(s_wd), .reg_rdata(s_rd),
    .sof_pulse(s_sof), .uframe_idx(s_idx));

  function automatic int exp_len(input int base, input int trim);
    return base + 16 * (trim & 63);
  endfunction

  function automatic int exp_read(input int trim);
    return trim & 63;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic s_measure(output int n);
    n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (!s_sof && n < 5000);
  endtask

  task automatic b_measure(output int n);
    n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (!b_sof && n < 70000);
  endtask

  task automatic s_write(input logic [7:0] w);
    @(negedge clk);
    s_sel = 1'b1; s_we = 1'b1; s_wd = w;
    @(negedge clk);
    s_we = 1'b0; #1;
  endtask

  task automatic s_read(output int v);
    s_sel = 1'b1; s_we = 1'b0; #1;
    v = int'(s_rd);
  endtask

  // short instance: directed and random stimulus
  initial begin
    int n, rv, trim_m, idx_m, len;
    logic [7:0] w;
    void'($urandom(32'd2024));
    s_core = 0; s_aon = 0; s_halt = 1; s_sel = 0; s_we = 0; s_wd = '0;
    repeat (3) @(negedge clk);
    s_core = 1; s_aon = 1;
    @(negedge clk); #1;
    check(s_sof == 0 && s_idx == 0, "R4 reset state", int'(s_idx), 0);
    check(s_rd == 0, "R2 unselected read", int'(s_rd), 0);
    s_read(rv);
    check(rv == 32, "R3 default trim", rv, 32);
    trim_m = 32; idx_m = 0;
    s_write(8'hFF);
    s_read(rv);
    check(rv == 63, "R2 reserved bits ignored", rv, 63);
    trim_m = 63;
    for (int it = 0; it < 12; it++) begin
      if (it == 0) w = 8'h00;
      else if (it == 1) w = 8'hBF;
      else w = 8'($urandom);
      s_write(w);
      trim_m = int'(w[5:0]);
      s_read(rv);
      check(rv == exp_read(trim_m), "R8 write while halted", rv, exp_read(trim_m));
      s_sel = 0;
      len = exp_len(SMALL_BASE, trim_m);
      @(negedge clk); s_halt = 0;
      s_measure(n);
      check(n == len, "R6 first SOF after release", n, len);
      idx_m++;
      check(int'(s_idx) == idx_m, "R7 index step", int'(s_idx), idx_m);
      @(negedge clk); #1;
      check(s_sof == 0, "R7 one-clock SOF", int'(s_sof), 0);
      s_measure(n);
      check(n + 1 == len, "R1 SOF period", n + 1, len);
      idx_m++;
      check(int'(s_idx) == idx_m, "R7 index step", int'(s_idx), idx_m);
      s_write(8'($urandom) ^ 8'h15);
      s_read(rv);
      check(rv == exp_read(trim_m), "R5 write while running ignored", rv, exp_read(trim_m));
      s_sel = 0;
      @(negedge clk); s_halt = 1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        check(s_sof == 0 && int'(s_idx) == idx_m, "R6 halted idle", int'(s_idx), idx_m);
      end
    end
    // core reset mid-frame
    len = exp_len(SMALL_BASE, trim_m);
    @(negedge clk); s_halt = 0;
    repeat (7) @(negedge clk);
    s_core = 0;
    @(negedge clk); #1;
    check(s_sof == 0 && s_idx == 0, "R4 core reset clears index", int'(s_idx), 0);
    s_read(rv);
    check(rv == exp_read(trim_m), "R4 trim survives core reset", rv, exp_read(trim_m));
    s_sel = 0;
    @(negedge clk); s_core = 1;
    s_measure(n);
    check(n == len && s_idx == 1, "R4 restart after core reset", n, len);
    // always-on reset
    @(negedge clk); s_halt = 1;
    @(negedge clk); s_aon = 0;
    @(negedge clk); s_aon = 1;
    s_read(rv);
    check(rv == 32, "R3 always-on reset default", rv, 32);
    s_sel = 0;
    s_done = 1;
  end

  // full-length instance: nominal and longest microframe
  initial begin
    int n, rv;
    b_core = 0; b_aon = 0; b_halt = 1; b_sel = 0; b_we = 0; b_wd = '0;
    repeat (3) @(negedge clk);
    b_core = 1; b_aon = 1;
    @(negedge clk);
    b_sel = 1; #1; rv = int'(b_rd);
    check(rv == 32, "R3 default read full", rv, 32);
    b_sel = 0;
    @(negedge clk); b_halt = 0;
    b_measure(n);
    check(n == exp_len(59488, 32), "R3 nominal 60000 clocks", n, exp_len(59488, 32));
    check(b_idx == 1, "R7 first index", int'(b_idx), 1);
    @(negedge clk); b_halt = 1;
    @(negedge clk); b_sel = 1; b_we = 1; b_wd = 8'h3F;
    @(negedge clk); b_we = 0; b_sel = 0; b_halt = 0;
    b_measure(n);
    check(n == exp_len(59488, 63), "R1 longest 60496 clocks", n, exp_len(59488, 63));
    b_done = 1;
  end

  initial begin
    fork
      wait (s_done && b_done);
      begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule